// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block feeds a network receiver with buffer space. A host places four-word buffer entries in a circular area of memory, bounded by a start pointer and an end pointer. The host also advances a write pointer as it refills the ring. On each fetch the block reads one entry through a simple request/acknowledge read port. It loads a 32-bit buffer address and a 32-bit remaining word count into working registers. It then moves its read pointer on by one entry, wrapping back to the start when it reaches the end. When the read pointer lands on the host's write pointer, it raises a sticky "ring exhausted" flag.

Three events start a fetch: an explicit command, a host clear of the exhausted flag, and the receive path reporting a packet that leaves the current buffer with fewer words than a programmable threshold. Only one fetch runs at a time. Triggers that arrive while a fetch is running are held and serviced one after another. The block also gives the receiver a single accept signal that refuses frames while reception is disabled or the ring is exhausted.

Top module: `rx_ring_fetcher`

## Requirements
- R1: After reset, busy, cmd_pending, exhausted, last_pkt and mem_req are 0, and rd_ptr, buf_addr and buf_words are 0.
- R2: A fetch issues four reads at {ptr_upper, rd_ptr} + k*S for k = 0..3. S is 2 bytes when cfg_wide=0 and 4 bytes when cfg_wide=1. Only mem_rdata[15:0] is used. The words are, in order, buffer address low, buffer address high, word count low and word count high, giving buf_addr = {w1,w0} and buf_words = {w3,w2}.
- R3: When a fetch completes, rd_ptr advances by 8 (narrow) or 16 (wide). If the result equals ring_end, rd_ptr becomes ring_start instead. rd_ptr changes at no other time, except through a host load (rdp_wr_en), which stores rdp_wr_data with bit 0 cleared.
- R4: When a completed fetch leaves rd_ptr equal to wr_ptr, exhausted is set. It stays set until a stat_clr pulse.
- R5: cmd_fetch starts a fetch. cmd_pending is 1 from the cycle after the pulse until the last command-started fetch completes.
- R6: A stat_clr pulse while exhausted=1 clears the flag and starts one fetch. A stat_clr pulse while exhausted=0 has no effect: no fetch runs and rd_ptr stays put.
- R7: On pkt_done, buf_words decreases by pkt_words. last_pkt is set when the result is below the threshold (unsigned, threshold zero-extended), and in that case one fetch is started. A result equal to the threshold clears last_pkt and starts nothing.
- R8: The threshold resets to 0x02F8 and takes thr_wr_data when thr_wr_en=1.
- R9: rx_accept is 1 exactly when rx_enable=1 and exhausted=0.
- R10: Only one fetch runs at a time. mem_req stays asserted with a stable address until mem_ack, and is 0 when not busy. Triggers raised during a fetch are held, and each held trigger gets its own fetch afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1: 32-bit memory words per entry field; 0: 16-bit |
| ptr_upper | input | 16 | Upper half of every ring memory address |
| ring_start | input | 16 | First entry of the ring |
| ring_end | input | 16 | One past the last entry of the ring |
| wr_ptr | input | 16 | Host write pointer |
| rdp_wr_en | input | 1 | Host load of the read pointer |
| rdp_wr_data | input | 16 | Value for the read pointer load |
| thr_wr_en | input | 1 | Host load of the low-count threshold |
| thr_wr_data | input | 16 | Value for the threshold load |
| cmd_fetch | input | 1 | Command pulse: fetch one entry |
| stat_clr | input | 1 | Host pulse clearing the exhausted flag |
| rx_enable | input | 1 | Receiver enabled |
| pkt_done | input | 1 | Receive path finished a packet |
| pkt_words | input | 16 | Words the finished packet consumed |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_ack | input | 1 | Memory read data valid, request accepted |
| mem_rdata | input | 32 | Memory read data |
| rd_ptr | output | 16 | Ring read pointer |
| buf_addr | output | 32 | Current buffer address |
| buf_words | output | 32 | Remaining words in current buffer |
| busy | output | 1 | A fetch is in progress |
| cmd_pending | output | 1 | A command-started fetch is outstanding |
| exhausted | output | 1 | Ring exhausted flag |
| last_pkt | output | 1 | Last packet left the buffer below threshold |
| rx_accept | output | 1 | Receiver may take a frame |

## Verification
On every cycle the assertions check that a request holds its address until acknowledged and that no request is made while idle. They also check that the read pointer moves only during a fetch or a host load, that the exhausted flag only drops on a clear, that a refused receiver never sees accept, and that an idle command is never dropped. The bench scenarios cover the data side. These are the captured address and count for each entry in both word widths, and the wrap point. They also include the exact boundary between equal-to and below threshold, and the distinction between clears that fetch and clears that do nothing. Another scenario checks that a trigger latched during a stalled fetch really produces a second fetch.

// File: rtl/rrf_pkg.sv
// Shared types and constants for the receive buffer ring fetcher.
package rrf_pkg;
    // Fetch sequencer states
    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_READ   = 2'd1,
        FS_COMMIT = 2'd2
    } fetch_state_t;

    // Number of memory words per ring entry
    localparam int FIELDS  = 4;
    // Trigger sources, lowest index wins when several are held
    localparam int NUM_SRC = 3;
    localparam int SRC_CMD = 0;
    localparam int SRC_CLR = 1;
    localparam int SRC_LOW = 2;
endpackage

// File: rtl/rrf_trigger_queue.sv
// Holds one pending flag per fetch trigger source and picks the next one.
// Assumes the consumer asserts take only when any_pend is 1; a raise in the
// same cycle as the take of that source keeps the flag set (new request).
module rrf_trigger_queue #(
    parameter int NSRC = 3,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] raise,
    input  logic            take,
    output logic            any_pend,
    output logic [IW-1:0]   pick,
    output logic [NSRC-1:0] pend
);
    // One pending latch per source
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (raise[g])
                pend[g] <= 1'b1;
            else if (take && (pick == IW'(g)))
                pend[g] <= 1'b0;
        end
    end

    // Fixed priority: lowest set index is served first
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) pick = IW'(i);
        end
    end

    assign any_pend = |pend;
endmodule

// File: rtl/rrf_entry_reader.sv
// Reads the four words of one ring entry through a request/acknowledge port.
// Assumes start is only asserted while busy is 0. The base address and the
// word width are latched at start, so they may change during the fetch.
module rrf_entry_reader import rrf_pkg::*; #(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 16,
    parameter int BUS_W       = 32,
    localparam int IDX_W      = $clog2(FIELDS),
    localparam int NARROW_SH  = $clog2(WORD_W / 8),
    localparam int WIDE_SH    = $clog2(BUS_W / 8)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base,
    input  logic                     wide,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    input  logic                     mem_ack,
    input  logic [BUS_W-1:0]         mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [FIELDS*WORD_W-1:0] fields
);
    fetch_state_t       state;
    logic [IDX_W-1:0]   idx;
    logic [ADDR_W-1:0]  base_q;
    logic               wide_q;
    logic [ADDR_W-1:0]  offset;
    logic               beat;

    assign beat = (state == FS_READ) && mem_ack;

    // Sequencer: idle, four reads, one commit cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FS_IDLE;
            idx    <= '0;
            base_q <= '0;
            wide_q <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (start) begin
                        state  <= FS_READ;
                        idx    <= '0;
                        base_q <= base;
                        wide_q <= wide;
                    end
                end
                FS_READ: begin
                    if (mem_ack) begin
                        if (idx == IDX_W'(FIELDS - 1))
                            state <= FS_COMMIT;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Byte offset of the current word inside the entry
    always_comb begin
        offset = '0;
        offset[IDX_W-1:0] = idx;
        offset = wide_q ? (offset << WIDE_SH) : (offset << NARROW_SH);
    end

    assign mem_req  = (state == FS_READ);
    assign mem_addr = base_q + offset;
    assign busy     = (state != FS_IDLE);
    assign done     = (state == FS_COMMIT);

    // Capture each returned word into its own field slot
    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n)
                fields[g*WORD_W +: WORD_W] <= '0;
            else if (beat && (idx == IDX_W'(g)))
                fields[g*WORD_W +: WORD_W] <= mem_rdata[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/rrf_ptr_next.sv
// Combinational next read pointer: advance by one entry, wrap at the end
// pointer, and compare the result with the host write pointer.
module rrf_ptr_next #(
    parameter int PTR_W       = 16,
    parameter int NARROW_STEP = 8,
    parameter int WIDE_STEP   = 16
) (
    input  logic [PTR_W-1:0] cur,
    input  logic [PTR_W-1:0] ring_start,
    input  logic [PTR_W-1:0] ring_end,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             wide,
    output logic [PTR_W-1:0] nxt,
    output logic             hit_wr
);
    logic [PTR_W-1:0] stepped;

    // Advance, then wrap, then compare against the writer
    always_comb begin
        stepped = cur + (wide ? PTR_W'(WIDE_STEP) : PTR_W'(NARROW_STEP));
        nxt     = (stepped == ring_end) ? ring_start : stepped;
        hit_wr  = (nxt == wr_ptr);
    end
endmodule

// File: rtl/rrf_count_tracker.sv
// Tracks the remaining word count of the current buffer and the low-count
// threshold. A fetch load takes precedence over a same-cycle packet report.
module rrf_count_tracker #(
    parameter int CNT_W              = 32,
    parameter int PKT_W              = 16,
    parameter int THR_W              = 16,
    parameter logic [THR_W-1:0] THR_RESET = 16'h02F8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             pkt_done,
    input  logic [PKT_W-1:0] pkt_words,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_val,
    output logic [CNT_W-1:0] words,
    output logic             last_pkt,
    output logic             low_hit
);
    logic [THR_W-1:0] thr;
    logic [CNT_W-1:0] remain;

    // Count left after the reported packet and its threshold compare
    always_comb begin
        remain  = words - CNT_W'(pkt_words);
        low_hit = pkt_done && (remain < CNT_W'(thr));
    end

    // Remaining-count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            words <= '0;
        else if (load)
            words <= load_val;
        else if (pkt_done)
            words <= remain;
    end

    // Last-packet flag reflects the most recent packet report
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_pkt <= 1'b0;
        else if (pkt_done)
            last_pkt <= low_hit;
    end

    // Threshold register
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr <= THR_RESET;
        else if (thr_wr)
            thr <= thr_val;
    end
endmodule

// File: rtl/rx_ring_fetcher.sv
// Receive buffer ring fetcher top. Combines the trigger queue, the entry
// reader, the pointer step and the count tracker, and owns the read
// pointer, the buffer address and the exhausted flag. Assumes the host
// keeps ring_start, ring_end and wr_ptr entry-aligned.
module rx_ring_fetcher import rrf_pkg::*; #(
    parameter int PTR_W   = 16,
    parameter int UPPER_W = 16,
    parameter int WORD_W  = 16,
    parameter int BUS_W   = 32,
    parameter logic [WORD_W-1:0] THR_RESET = 16'h02F8,
    localparam int ADDR_W = UPPER_W + PTR_W,
    localparam int BUF_W  = 2 * WORD_W,
    localparam int NARROW_STEP = FIELDS * WORD_W / 8,
    localparam int WIDE_STEP   = FIELDS * BUS_W / 8,
    localparam int SRC_IW = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic [UPPER_W-1:0] ptr_upper,
    input  logic [PTR_W-1:0]   ring_start,
    input  logic [PTR_W-1:0]   ring_end,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic               rdp_wr_en,
    input  logic [PTR_W-1:0]   rdp_wr_data,
    input  logic               thr_wr_en,
    input  logic [WORD_W-1:0]  thr_wr_data,
    input  logic               cmd_fetch,
    input  logic               stat_clr,
    input  logic               rx_enable,
    input  logic               pkt_done,
    input  logic [WORD_W-1:0]  pkt_words,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic [BUS_W-1:0]   mem_rdata,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [BUF_W-1:0]   buf_addr,
    output logic [BUF_W-1:0]   buf_words,
    output logic               busy,
    output logic               cmd_pending,
    output logic               exhausted,
    output logic               last_pkt,
    output logic               rx_accept
);
    logic [NUM_SRC-1:0]       raise;
    logic [NUM_SRC-1:0]       pend;
    logic                     any_pend;
    logic [SRC_IW-1:0]        pick;
    logic [SRC_IW-1:0]        cur_src;
    logic                     start;
    logic                     done;
    logic                     clr_live;
    logic                     low_hit;
    logic [FIELDS*WORD_W-1:0] fields;
    logic [PTR_W-1:0]         ptr_nxt;
    logic                     ptr_hit;

    // A clear only counts while the flag is actually set
    assign clr_live = stat_clr && exhausted;

    // Trigger vector in priority order
    always_comb begin
        raise          = '0;
        raise[SRC_CMD] = cmd_fetch;
        raise[SRC_CLR] = clr_live;
        raise[SRC_LOW] = low_hit;
    end

    assign start = any_pend && !busy;

    rrf_trigger_queue #(.NSRC(NUM_SRC)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .raise    (raise),
        .take     (start),
        .any_pend (any_pend),
        .pick     (pick),
        .pend     (pend)
    );

    // Remember which source the running fetch serves
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_src <= '0;
        else if (start)
            cur_src <= pick;
    end

    rrf_entry_reader #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base      ({ptr_upper, rd_ptr}),
        .wide      (cfg_wide),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .fields    (fields)
    );

    rrf_ptr_next #(
        .PTR_W       (PTR_W),
        .NARROW_STEP (NARROW_STEP),
        .WIDE_STEP   (WIDE_STEP)
    ) u_step (
        .cur        (rd_ptr),
        .ring_start (ring_start),
        .ring_end   (ring_end),
        .wr_ptr     (wr_ptr),
        .wide       (cfg_wide),
        .nxt        (ptr_nxt),
        .hit_wr     (ptr_hit)
    );

    rrf_count_tracker #(
        .CNT_W     (BUF_W),
        .PKT_W     (WORD_W),
        .THR_W     (WORD_W),
        .THR_RESET (THR_RESET)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (done),
        .load_val  (fields[2*WORD_W +: BUF_W]),
        .pkt_done  (pkt_done),
        .pkt_words (pkt_words),
        .thr_wr    (thr_wr_en),
        .thr_val   (thr_wr_data),
        .words     (buf_words),
        .last_pkt  (last_pkt),
        .low_hit   (low_hit)
    );

    // Read pointer: fetch completion wins over a host load
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_ptr <= '0;
        else if (done)
            rd_ptr <= ptr_nxt;
        else if (rdp_wr_en)
            rd_ptr <= {rdp_wr_data[PTR_W-1:1], 1'b0};
    end

    // Buffer address register loaded at completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_addr <= '0;
        else if (done)
            buf_addr <= fields[0 +: BUF_W];
    end

    // Sticky exhausted flag: set on pointer meet, cleared by host
    always_ff @(posedge clk) begin
        if (!rst_n)
            exhausted <= 1'b0;
        else if (done && ptr_hit)
            exhausted <= 1'b1;
        else if (clr_live)
            exhausted <= 1'b0;
    end

    assign cmd_pending = pend[SRC_CMD] || (busy && (cur_src == SRC_IW'(SRC_CMD)));
    assign rx_accept   = rx_enable && !exhausted;
endmodule

// File: rtl/rrf_checker.sv
// Protocol and state checks for the receive buffer ring fetcher, bound
// to every instance of the top module.
module rrf_checker #(
    parameter int PTR_W  = 16,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              rdp_wr_en,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic              exhausted,
    input logic              stat_clr,
    input logic              rx_enable,
    input logic              rx_accept,
    input logic              cmd_pending
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_ptr_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rdp_wr_en) |=> $stable(rd_ptr));

    assert_exh_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && !stat_clr) |=> exhausted);

    assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted || !rx_enable) |-> !rx_accept);

    assert_cmd_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pending && !busy) |=> cmd_pending);
endmodule

bind rx_ring_fetcher rrf_checker #(
    .PTR_W  (PTR_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .busy        (busy),
    .rdp_wr_en   (rdp_wr_en),
    .rd_ptr      (rd_ptr),
    .exhausted   (exhausted),
    .stat_clr    (stat_clr),
    .rx_enable   (rx_enable),
    .rx_accept   (rx_accept),
    .cmd_pending (cmd_pending)
);

// File: tb/sim_rx_ring_fetcher.sv
`timescale 1ns/1ps
// Self-checking bench: arithmetic memory model, sweeps over both widths.
module sim_rx_ring_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b0;
    logic [15:0] ptr_upper = 16'h1234;
    logic [15:0] ring_start = 16'h0100;
    logic [15:0] ring_end = 16'h0120;
    logic [15:0] wr_ptr = 16'hF000;
    logic        rdp_wr_en = 1'b0;
    logic [15:0] rdp_wr_data = '0;
    logic        thr_wr_en = 1'b0;
    logic [15:0] thr_wr_data = '0;
    logic        cmd_fetch = 1'b0;
    logic        stat_clr = 1'b0;
    logic        rx_enable = 1'b1;
    logic        pkt_done = 1'b0;
    logic [15:0] pkt_words = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic [15:0] rd_ptr;
    logic [31:0] buf_addr;
    logic [31:0] buf_words;
    logic        busy, cmd_pending, exhausted, last_pkt, rx_accept;

    int  vecs = 0;
    int  errs = 0;
    int  bad_upper = 0;
    bit  done_flag = 0;
    logic ack_tog = 1'b0;
    logic ack_en = 1'b1;
    logic zero_hi = 1'b0;

    always #2 clk = ~clk;

    rx_ring_fetcher u0 (.*);

    // Memory model: word value computed from its address
    function automatic logic [15:0] mw(input logic [15:0] a);
        logic [1:0] fld;
        fld = cfg_wide ? a[3:2] : a[2:1];
        if (zero_hi && fld == 2'd3) return 16'h0000;
        return a ^ 16'h5A5A;
    endfunction

    always_ff @(posedge clk) ack_tog <= ~ack_tog;
    always_comb begin
        mem_ack   = mem_req && ack_tog && ack_en;
        mem_rdata = {16'hC3C3, mw(mem_addr[15:0])};
    end
    always_ff @(posedge clk) if (mem_req && mem_addr[31:16] != ptr_upper) bad_upper <= bad_upper + 1;

    function automatic int step();
        return cfg_wide ? 16 : 8;
    endfunction
    function automatic logic [31:0] exp_addr(input logic [15:0] e);
        int s = cfg_wide ? 4 : 2;
        return {mw(e + 16'(s)), mw(e)};
    endfunction
    function automatic logic [31:0] exp_words(input logic [15:0] e);
        int s = cfg_wide ? 4 : 2;
        return {mw(e + 16'(3*s)), mw(e + 16'(2*s))};
    endfunction
    function automatic logic [15:0] adv(input logic [15:0] p);
        logic [15:0] n = p + 16'(step());
        return (n == ring_end) ? ring_start : n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    task automatic settle();
        int quiet = 0;
        int guard = 0;
        while (quiet < 3 && guard < 500) begin
            @(negedge clk);
            if (busy || cmd_pending) quiet = 0; else quiet++;
            guard++;
        end
    endtask

    task automatic do_cmd();
        @(negedge clk) cmd_fetch = 1'b1;
        @(negedge clk) cmd_fetch = 1'b0;
    endtask
    task automatic do_clr();
        @(negedge clk) stat_clr = 1'b1;
        @(negedge clk) stat_clr = 1'b0;
    endtask
    task automatic do_pkt(input logic [15:0] p);
        @(negedge clk) begin pkt_done = 1'b1; pkt_words = p; end
        @(negedge clk) pkt_done = 1'b0;
    endtask
    task automatic load_rd(input logic [15:0] v);
        @(negedge clk) begin rdp_wr_en = 1'b1; rdp_wr_data = v; end
        @(negedge clk) rdp_wr_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errs++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [15:0] rdm;
        logic [15:0] e;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'b0, busy}, 0);
        chk("R1 cmd_pending", {31'b0, cmd_pending}, 0);
        chk("R1 exhausted", {31'b0, exhausted}, 0);
        chk("R1 last_pkt", {31'b0, last_pkt}, 0);
        chk("R1 mem_req", {31'b0, mem_req}, 0);
        chk("R1 rd_ptr", {16'b0, rd_ptr}, 0);
        chk("R1 buf_addr", buf_addr, 0);
        chk("R1 buf_words", buf_words, 0);

        // R2/R3 sweep over both widths, through the wrap point
        for (int w8 = 0; w8 < 2; w8++) begin
            cfg_wide = w8[0];
            ring_end = ring_start + 16'(4 * step());
            load_rd(16'h0101);
            chk("R3 host load clears bit0", {16'b0, rd_ptr}, 32'h0100);
            rdm = 16'h0100;
            for (int i = 0; i < 6; i++) begin
                e = rdm;
                do_cmd();
                settle();
                rdm = adv(rdm);
                chk("R2 buf_addr", buf_addr, exp_addr(e));
                chk("R2 buf_words", buf_words, exp_words(e));
                chk("R3 rd_ptr step/wrap", {16'b0, rd_ptr}, {16'b0, rdm});
                chk("R5 cmd_pending cleared", {31'b0, cmd_pending}, 0);
                chk("R4 no exhaustion", {31'b0, exhausted}, 0);
            end
        end
        chk("R2 upper address half", bad_upper, 0);

        // R10/R5 stalled fetch with a second command latched
        cfg_wide = 1'b0;
        ring_end = 16'h0120;
        load_rd(16'h0100);
        ack_en = 1'b0;
        do_cmd();
        @(negedge clk);
        chk("R10 busy during stall", {31'b0, busy}, 1);
        chk("R10 mem_req held", {31'b0, mem_req}, 1);
        chk("R2 first address", mem_addr, 32'h12340100);
        chk("R5 cmd_pending set", {31'b0, cmd_pending}, 1);
        do_cmd();
        repeat (3) @(negedge clk);
        chk("R10 address stable", mem_addr, 32'h12340100);
        ack_en = 1'b1;
        settle();
        chk("R10 latched trigger served", {16'b0, rd_ptr}, 32'h0110);
        chk("R10 second entry loaded", buf_addr, exp_addr(16'h0108));
        chk("R5 cmd_pending after both", {31'b0, cmd_pending}, 0);

        // R4/R6/R9 exhaustion and host clear
        wr_ptr = 16'h0110;
        load_rd(16'h0100);
        do_cmd(); settle();
        chk("R4 not yet exhausted", {31'b0, exhausted}, 0);
        do_cmd(); settle();
        chk("R4 exhausted on meet", {31'b0, exhausted}, 1);
        chk("R9 refused when exhausted", {31'b0, rx_accept}, 0);
        wr_ptr = 16'hF000;
        do_cmd(); settle();
        chk("R4 flag sticky", {31'b0, exhausted}, 1);
        chk("R3 rd after sticky fetch", {16'b0, rd_ptr}, 32'h0118);
        do_clr(); settle();
        chk("R6 clear drops flag", {31'b0, exhausted}, 0);
        chk("R6 clear starts fetch", {16'b0, rd_ptr}, 32'h0100);
        chk("R6 clear fetch data", buf_addr, exp_addr(16'h0118));
        chk("R9 accept restored", {31'b0, rx_accept}, 1);
        do_clr(); settle();
        chk("R6 idle clear no effect", {16'b0, rd_ptr}, 32'h0100);
        wr_ptr = 16'h0100;
        load_rd(16'h0118);
        do_cmd(); settle();
        chk("R4 exhaustion at wrap", {31'b0, exhausted}, 1);
        chk("R3 wrapped", {16'b0, rd_ptr}, 32'h0100);
        wr_ptr = 16'hF000;
        do_clr(); settle();
        rx_enable = 1'b0;
        @(negedge clk);
        chk("R9 refused when disabled", {31'b0, rx_accept}, 0);
        rx_enable = 1'b1;

        // R7/R8 low-count boundary with default then written threshold
        zero_hi = 1'b1;
        load_rd(16'h0100);
        do_cmd(); settle();
        w = exp_words(16'h0100);
        chk("R2 count high zero", buf_words, w);
        do_pkt(w[15:0] - 16'h02F8); settle();
        chk("R8 default threshold equal not low", {31'b0, last_pkt}, 0);
        chk("R7 equal starts nothing", {16'b0, rd_ptr}, 32'h0108);
        chk("R7 count decremented", buf_words, 32'h02F8);
        do_pkt(16'd1); settle();
        chk("R7 below sets last_pkt", {31'b0, last_pkt}, 1);
        chk("R7 below fetches", {16'b0, rd_ptr}, 32'h0110);
        chk("R7 reloaded count", buf_words, exp_words(16'h0108));
        @(negedge clk) begin thr_wr_en = 1'b1; thr_wr_data = 16'h0010; end
        @(negedge clk) thr_wr_en = 1'b0;
        w = buf_words;
        do_pkt(w[15:0] - 16'h0010); settle();
        chk("R8 written threshold equal", {31'b0, last_pkt}, 0);
        chk("R8 no fetch", {16'b0, rd_ptr}, 32'h0110);
        do_pkt(16'd1); settle();
        chk("R8 written threshold below", {31'b0, last_pkt}, 1);
        chk("R8 fetch on low", {16'b0, rd_ptr}, 32'h0118);

        report();
    end
endmodule